// File: doc/BRIEF.md
# 16-to-8-bit bus width bridge

This block sits between a processor with a 16-bit data bus and a memory with an 8-bit data bus. The processor runs ordinary 16-bit bus cycles and does not see the narrow memory behind the bridge. The bridge decodes address bit 0 and the active-low byte-high enable to find which byte lanes the processor wants.

A single-byte access is steered between the memory's one lane and the processor lane it belongs to. A full word access is split into two 8-bit memory accesses: first the even byte, then the odd byte. For a word read, the first byte is latched inside the bridge, and the complete word is presented when the second access ends. Each memory access takes a parameterised number of wait clocks. The processor is stalled by a ready handshake until the last access of its cycle has finished.

The processor raises a read or write strobe and holds the address, the byte enable and the write data. It keeps them until ready rises. Ready then stays high until the strobe is released.

Top module: `bus_width_bridge`

## Requirements
- R1: While reset is asserted, cpu_ready and mem_dout_en are 0, and mem_cs_n, mem_oe_n and mem_we_n are 1.
- R2: Lanes are decoded from cpu_addr[0] and cpu_bhe_n as follows. A0=0 with cpu_bhe_n=0 is a word. A0=0 with cpu_bhe_n=1 is the low byte only. A0=1 with cpu_bhe_n=0 is the high byte only. A byte access performs exactly one memory access, at cpu_addr.
- R3: A low-byte read returns the memory byte on cpu_rdata[7:0], with cpu_rdata[15:8] equal to 0.
- R4: A high-byte read returns the memory byte at the odd address on cpu_rdata[15:8], with cpu_rdata[7:0] equal to 0.
- R5: A byte write puts cpu_wdata[7:0] (low byte) or cpu_wdata[15:8] (high byte) into the addressed memory byte. The neighbouring memory byte is left unchanged.
- R6: A word access performs two memory accesses in order: cpu_addr (even, low byte) first, then cpu_addr+1 (high byte).
- R7: A word read returns {byte at cpu_addr+1, byte at cpu_addr} on cpu_rdata together with cpu_ready.
- R8: During each memory access, mem_cs_n stays low and mem_addr stays stable for WAIT_CYC+2 clocks. For a write, mem_we_n is low for the first WAIT_CYC+1 of those clocks.
- R9: cpu_ready is low from the edge that accepts a strobe until the last access ends. It rises WAIT_CYC+3 clocks after acceptance for a byte access and 2*WAIT_CYC+5 clocks after acceptance for a word access. It stays high until the strobe is released, and the memory is idle while it is high.
- R10: mem_dout_en is high only during write accesses and mem_oe_n is low only during read accesses. The two are never active together.
- R11: A strobe with A0=1 and cpu_bhe_n=1 selects no lane. It starts no memory access, returns cpu_rdata of 0, and raises cpu_ready one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_bhe_n | input | 1 | Active-low high byte enable |
| cpu_rd | input | 1 | Read strobe, held until ready |
| cpu_wr | input | 1 | Write strobe, held until ready |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Read data, valid with ready |
| cpu_ready | output | 1 | Cycle complete |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_din | input | 8 | Data from memory |
| mem_dout | output | 8 | Data to memory |
| mem_dout_en | output | 1 | Drive enable for mem_dout |

## Verification
The bridge is exercised with every lane pattern: even-byte and odd-byte reads and writes, word reads and writes, and the combination that selects no lane. The memory model is seeded with distinct bytes at every address. A byte taken from the wrong lane or address, or a swap of the two halves of a word, therefore shows up as a value mismatch. The bench logs each memory access and counts clocks per access and per processor cycle. This separates an access order that is wrong, a hold time that is cut short, and a ready that comes early or late. After each byte write, the untouched neighbour byte is also read back from the model, which catches a write landing on both lanes.

// File: rtl/bus_width_bridge.sv
module bus_width_bridge #(
  parameter int ADDR_W   = 20,
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_bhe_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata,
  output logic              cpu_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  input  logic [7:0]        mem_din,
  output logic [7:0]        mem_dout,
  output logic              mem_dout_en
);
  localparam int SLOT = WAIT_CYC + 2;
  localparam int CW   = $clog2(SLOT + 1);

  typedef enum logic [1:0] {IDLE, ACC, DONE} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic          second;
  logic [15:0]   rdata_q;

  wire is_word  = !cpu_addr[0] && !cpu_bhe_n;
  wire any_lane = !cpu_addr[0] || !cpu_bhe_n;
  wire hi_sel   = cpu_addr[0] | second;
  wire last     = (cnt == CW'(SLOT - 1));
  wire busy     = (st == ACC);
  wire wr_op    = cpu_wr && !cpu_rd;
  wire strobe   = cpu_rd || cpu_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      second  <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (st)
        IDLE: if (strobe) begin
          rdata_q <= '0;
          second  <= 1'b0;
          cnt     <= '0;
          st      <= any_lane ? ACC : DONE;
        end
        ACC: if (last) begin
          if (cpu_rd) begin
            if (hi_sel) rdata_q[15:8] <= mem_din;
            else        rdata_q[7:0]  <= mem_din;
          end
          if (is_word && !second) begin
            second <= 1'b1;
            cnt    <= '0;
          end else begin
            st <= DONE;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
        DONE: if (!strobe) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign mem_addr    = {cpu_addr[ADDR_W-1:1], cpu_addr[0] | second};
  assign mem_cs_n    = !busy;
  assign mem_oe_n    = !(busy && cpu_rd);
  assign mem_we_n    = !(busy && wr_op && !last);
  assign mem_dout_en = busy && wr_op;
  assign mem_dout    = hi_sel ? cpu_wdata[15:8] : cpu_wdata[7:0];
  assign cpu_rdata   = rdata_q;
  assign cpu_ready   = (st == DONE);
endmodule

module bus_width_bridge_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              cpu_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dout_en
);
  // R10
  oe_drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dout_en && !mem_oe_n));
  // R10
  drive_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> !mem_cs_n);
  // R8
  we_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
  // R9
  ready_idle_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> mem_cs_n);
  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && (cpu_rd || cpu_wr)) |=> cpu_ready);
endmodule

bind bus_width_bridge bus_width_bridge_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_ready(cpu_ready), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dout_en(mem_dout_en)
);

// File: tb/test_bus_width_bridge.sv
module test_bus_width_bridge;
  localparam int AW   = 8;
  localparam int WC   = 2;
  localparam int SLOT = WC + 2;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_bhe_n = 1;
  logic          cpu_rd = 0, cpu_wr = 0;
  logic [15:0]   cpu_wdata = '0;
  logic [15:0]   cpu_rdata;
  logic          cpu_ready;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [7:0]    mem_din, mem_dout;

  always #4 clk = ~clk;

  bus_width_bridge #(.ADDR_W(AW), .WAIT_CYC(WC)) i_bus_width_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_bhe_n(cpu_bhe_n),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_din(mem_din), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en));

  logic [7:0] memb [0:255];
  assign mem_din = (!mem_cs_n && !mem_oe_n) ? memb[mem_addr] : 8'h00;
  always @(posedge clk)
    if (!mem_cs_n && !mem_we_n && mem_dout_en) memb[mem_addr] <= mem_dout;

  int nchk = 0, nerr = 0;
  int nlog, nseg, nwe, oe_cnt, den_cnt, seg, werun;
  logic [AW-1:0] alog [0:7];
  int seglen [0:7];
  int welen [0:7];
  logic prev_act = 0, prev_we = 0;
  logic [AW-1:0] prev_addr = '0;
  bit finished = 0;

  always @(negedge clk) begin
    if (!mem_cs_n) begin
      if (prev_act && mem_addr == prev_addr) seg++;
      else begin
        if (prev_act) begin seglen[nseg] = seg; nseg++; end
        seg = 1; alog[nlog] = mem_addr; nlog++;
      end
    end else if (prev_act) begin seglen[nseg] = seg; nseg++; end
    if (!mem_we_n) werun = prev_we ? werun + 1 : 1;
    else if (prev_we) begin welen[nwe] = werun; nwe++; end
    if (!mem_oe_n) oe_cnt++;
    if (mem_dout_en) den_cnt++;
    prev_act = !mem_cs_n; prev_addr = mem_addr; prev_we = !mem_we_n;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    nlog = 0; nseg = 0; nwe = 0; oe_cnt = 0; den_cnt = 0;
  endtask

  task automatic do_cycle(input bit rd, input logic [AW-1:0] a, input bit bhe_n,
                          input logic [15:0] wd, output logic [15:0] rdv, output int cyc);
    @(negedge clk);
    clear_log();
    cpu_addr = a; cpu_bhe_n = bhe_n; cpu_wdata = wd; cpu_rd = rd; cpu_wr = !rd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 200);
    rdv = cpu_rdata;
    cpu_rd = 0; cpu_wr = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(cpu_ready == 0, "R1 ready", int'(cpu_ready), 0);
    check({mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en} == 4'b1110, "R1 strobes",
          int'({mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en}), 4'b1110);
  endtask

  task automatic t_read_low();
    logic [15:0] r; int c;
    do_cycle(1, 8'h10, 1, 16'h0, r, c);
    check(r == {8'h00, memb[8'h10]}, "R3 low read", r, {8'h00, memb[8'h10]});
    check(nlog == 1 && alog[0] == 8'h10, "R2 one access at addr", int'(alog[0]), 8'h10);
    check(c == SLOT + 1, "R9 byte ready latency", c, SLOT + 1);
    check(den_cnt == 0 && oe_cnt == SLOT, "R10 read drives", den_cnt * 256 + oe_cnt, SLOT);
  endtask

  task automatic t_read_high();
    logic [15:0] r; int c;
    do_cycle(1, 8'h21, 0, 16'h0, r, c);
    check(r == {memb[8'h21], 8'h00}, "R4 high read", r, {memb[8'h21], 8'h00});
    check(nlog == 1 && alog[0] == 8'h21, "R2 odd access", int'(alog[0]), 8'h21);
  endtask

  task automatic t_write_low();
    logic [15:0] r; int c; logic [7:0] nb;
    nb = memb[8'h31];
    do_cycle(0, 8'h30, 1, 16'hA55A, r, c);
    check(memb[8'h30] == 8'h5A, "R5 low write", memb[8'h30], 8'h5A);
    check(memb[8'h31] == nb, "R5 neighbour kept", memb[8'h31], nb);
    check(oe_cnt == 0 && den_cnt == SLOT, "R10 write drives", oe_cnt * 256 + den_cnt, SLOT);
  endtask

  task automatic t_write_high();
    logic [15:0] r; int c; logic [7:0] nb;
    nb = memb[8'h40];
    do_cycle(0, 8'h41, 0, 16'hC33C, r, c);
    check(memb[8'h41] == 8'hC3, "R5 high write", memb[8'h41], 8'hC3);
    check(memb[8'h40] == nb, "R5 neighbour kept", memb[8'h40], nb);
  endtask

  task automatic t_word_read();
    logic [15:0] r; int c;
    do_cycle(1, 8'h52, 0, 16'h0, r, c);
    check(r == {memb[8'h53], memb[8'h52]}, "R7 word read", r, {memb[8'h53], memb[8'h52]});
    check(nlog == 2 && alog[0] == 8'h52 && alog[1] == 8'h53, "R6 read order",
          int'({alog[0], alog[1]}), 16'h5253);
    check(c == 2 * SLOT + 1, "R9 word ready latency", c, 2 * SLOT + 1);
  endtask

  task automatic t_word_write();
    logic [15:0] r; int c;
    do_cycle(0, 8'h64, 0, 16'hBEEF, r, c);
    check(memb[8'h64] == 8'hEF && memb[8'h65] == 8'hBE, "R6 word write",
          int'({memb[8'h65], memb[8'h64]}), 16'hBEEF);
    check(nlog == 2 && alog[0] == 8'h64 && alog[1] == 8'h65, "R6 write order",
          int'({alog[0], alog[1]}), 16'h6465);
    check(nseg == 2 && seglen[0] == SLOT && seglen[1] == SLOT, "R8 access length",
          seglen[0] * 256 + seglen[1], SLOT * 257);
    check(nwe == 2 && welen[0] == SLOT - 1 && welen[1] == SLOT - 1, "R8 we length",
          welen[0] * 256 + welen[1], (SLOT - 1) * 257);
  endtask

  task automatic t_no_lane();
    logic [15:0] r; int c; logic [7:0] b0, b1;
    memb[8'h71] = 8'h99;
    do_cycle(1, 8'h71, 1, 16'h0, r, c);
    check(c == 1 && nlog == 0, "R11 read no access", c * 256 + nlog, 256);
    check(r == 16'h0, "R11 read data", r, 0);
    b0 = memb[8'h70]; b1 = memb[8'h71];
    do_cycle(0, 8'h71, 1, 16'h1234, r, c);
    check(memb[8'h70] == b0 && memb[8'h71] == b1 && nlog == 0, "R11 write ignored",
          int'({memb[8'h70], memb[8'h71]}), int'({b0, b1}));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) memb[i] = 8'(i * 37 + 11);
    clear_log();
    seg = 0; werun = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_read_low();
    t_read_high();
    t_write_low();
    t_write_high();
    t_word_read();
    t_word_write();
    t_no_lane();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule